// File: doc/BRIEF.md
# Serial Command Memory Controller

This block sits between a byte-wide serial receiver and a 16-bit synchronous SRAM port. It assembles received bytes into 16-bit words and decodes them as a small command protocol. The host can fill memory with a burst write, fetch a burst of words back, or switch the controller between two read destinations. A burst is described by a word count and a starting address.

In memory mode, words read from the SRAM are split into bytes and returned to the serial transmitter. Reading stalls whenever the transmitter reports that its buffer is full. In processing mode, the same burst reads go to the packet-processing path as a 16-bit stream with a valid flag. One word is issued per clock, so a burst runs without gaps.

While a read burst is in progress, incoming words are discarded. The host is expected to wait until the burst has finished.

Top module: `sercmd_memctl`

## Requirements
- R1: Received bytes are paired into 16-bit words. The first byte of each pair becomes bits 15:8 and the second becomes bits 7:0.
- R2: Word 0x0000 starts a burst write. The next word is the count N and the word after that is the base address. The N words that follow are then written to the base address and the addresses above it. The address wraps modulo 2^ADDR_W.
- R3: Word 0x0001 starts a burst read. The next word is the count N and the word after that is the base address. N words are then read from consecutive addresses, in ascending order, with the same wrap as R2.
- R4: A count of zero causes no SRAM access. The word after the base address is decoded as a new command.
- R5: Word 0x0002 selects memory mode, which is also the mode after reset. In this mode each read word leaves on the transmit byte lane as two bytes, bits 15:8 first, and nothing appears on the processing stream.
- R6: Word 0x0003 selects processing mode. In this mode each read word appears on the processing stream with its valid flag, one word per clock for the whole burst, and nothing leaves on the transmit lane.
- R7: The transmit valid flag is never high while the transmit-full input is high. While that input stays high, no byte leaves the block.
- R8: Any other command code is ignored. It leaves the mode unchanged, and the next word is decoded as a command.
- R9: During and just after reset, there are no SRAM accesses, no transmit or stream valid, and the mode is memory mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_full | input | 1 | Transmit buffer cannot accept a byte |
| tx_valid | output | 1 | Byte on tx_byte is accepted this cycle |
| tx_byte | output | 8 | Byte returned to the serial link |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write (1) or read (0) |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after a read strobe |
| pp_valid | output | 1 | Stream word valid |
| pp_data | output | 16 | Stream word to packet processing |
| proc_mode | output | 1 | 1 in processing mode, 0 in memory mode |

## Verification
The bench builds the block with ADDR_W = 8, so its behavioural RAM has 256 words. This makes the address wrap at the top of memory easy to reach: a burst that starts at 0xFE crosses to address 0x00 within a few words. It also keeps the reference shadow small enough to compare in full. With the narrow address, both read destinations, a held transmit-full stall, zero-length bursts and unknown codes can all be exercised in a short run.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [WORD_W-1:0] OP_WRITE = 16'h0000;
    localparam logic [WORD_W-1:0] OP_READ  = 16'h0001;
    localparam logic [WORD_W-1:0] OP_MEM   = 16'h0002;
    localparam logic [WORD_W-1:0] OP_PROC  = 16'h0003;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_LEN,
        ST_BASE,
        ST_WDATA,
        ST_READ
    } dec_state_e;
endpackage

// File: rtl/smc_byte_pack.sv
module smc_byte_pack
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              half;
        logic [BYTE_W-1:0] hi;
        logic              vld;
        logic [WORD_W-1:0] word;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        pk_d     = pk_q;
        pk_d.vld = 1'b0;
        if (rx_valid) begin
            if (!pk_q.half) begin
                pk_d.hi   = rx_byte;
                pk_d.half = 1'b1;
            end else begin
                pk_d.word = {pk_q.hi, rx_byte};
                pk_d.vld  = 1'b1;
                pk_d.half = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_vld = pk_q.vld;
    assign word     = pk_q.word;

    // R1: a word needs two bytes, so completed words never come back to back
    a_r1_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
endmodule

// File: rtl/smc_cmd_fsm.sv
module smc_cmd_fsm
    import smc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              split_empty,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [WORD_W-1:0] sram_wdata,
    output logic              ret_vld,
    output logic              ret_proc,
    output logic              proc_mode
);
    localparam int LEN_W = WORD_W;

    typedef struct packed {
        dec_state_e        st;
        logic              op_wr;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] ptr;
        logic              proc;
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic              dest;
        logic              ret;
        logic              ret_dest;
    } dec_t;

    dec_t dc_d, dc_q;
    logic rd_busy;
    logic last;

    always_comb begin
        dc_d          = dc_q;
        dc_d.en       = 1'b0;
        dc_d.we       = 1'b0;
        dc_d.ret      = dc_q.en & ~dc_q.we;
        dc_d.ret_dest = dc_q.dest;
        rd_busy       = (dc_q.en & ~dc_q.we) | dc_q.ret;
        last          = (dc_q.len == LEN_W'(1));
        unique case (dc_q.st)
            ST_CMD: if (word_vld) begin
                unique case (word)
                    OP_WRITE: begin dc_d.op_wr = 1'b1; dc_d.st = ST_LEN; end
                    OP_READ:  begin dc_d.op_wr = 1'b0; dc_d.st = ST_LEN; end
                    OP_MEM:   dc_d.proc = 1'b0;
                    OP_PROC:  dc_d.proc = 1'b1;
                    default:  ;
                endcase
            end
            ST_LEN: if (word_vld) begin
                dc_d.len = word;
                dc_d.st  = ST_BASE;
            end
            ST_BASE: if (word_vld) begin
                dc_d.ptr = word[ADDR_W-1:0];
                if (dc_q.len == '0)  dc_d.st = ST_CMD;
                else if (dc_q.op_wr) dc_d.st = ST_WDATA;
                else                 dc_d.st = ST_READ;
            end
            ST_WDATA: if (word_vld) begin
                dc_d.en    = 1'b1;
                dc_d.we    = 1'b1;
                dc_d.addr  = dc_q.ptr;
                dc_d.wdata = word;
                dc_d.ptr   = dc_q.ptr + 1'b1;
                dc_d.len   = dc_q.len - 1'b1;
                if (last) dc_d.st = ST_CMD;
            end
            ST_READ: if (dc_q.proc || (split_empty && !rd_busy)) begin
                dc_d.en   = 1'b1;
                dc_d.addr = dc_q.ptr;
                dc_d.dest = dc_q.proc;
                dc_d.ptr  = dc_q.ptr + 1'b1;
                dc_d.len  = dc_q.len - 1'b1;
                if (last) dc_d.st = ST_CMD;
            end
            default: dc_d.st = ST_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dc_q <= '{st: ST_CMD, default: '0};
        else        dc_q <= dc_d;
    end

    assign sram_en    = dc_q.en;
    assign sram_we    = dc_q.we;
    assign sram_addr  = dc_q.addr;
    assign sram_wdata = dc_q.wdata;
    assign ret_vld    = dc_q.ret;
    assign ret_proc   = dc_q.ret_dest;
    assign proc_mode  = dc_q.proc;

    // R2: every SRAM write is caused by a word completed in the previous cycle
    a_r2_write_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && sram_we) |-> $past(word_vld));

    // R3: back-to-back accesses within a burst step the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en && $past(sram_en)) |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));
endmodule

// File: rtl/smc_rd_route.sv
module smc_rd_route
    import smc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_vld,
    input  logic              ret_proc,
    input  logic [WORD_W-1:0] rdata,
    input  logic              tx_full,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              pp_valid,
    output logic [WORD_W-1:0] pp_data,
    output logic              split_empty
);
    typedef struct packed {
        logic [1:0]        cnt;
        logic [WORD_W-1:0] hold;
    } split_t;

    split_t sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (ret_vld && !ret_proc) begin
            sp_d.hold = rdata;
            sp_d.cnt  = 2'd2;
        end else if (sp_q.cnt != 2'd0 && !tx_full) begin
            sp_d.cnt = sp_q.cnt - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign tx_valid    = (sp_q.cnt != 2'd0) && !tx_full;
    assign tx_byte     = (sp_q.cnt == 2'd2) ? sp_q.hold[WORD_W-1:BYTE_W] : sp_q.hold[BYTE_W-1:0];
    assign pp_valid    = ret_vld && ret_proc;
    assign pp_data     = rdata;
    assign split_empty = (sp_q.cnt == 2'd0);

    // R7: no byte is offered while the transmitter is full
    a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_valid);

    // R5: the decoder only returns a memory-mode word once the splitter has drained
    a_r5_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && !ret_proc) |-> (sp_q.cnt == 2'd0));
endmodule

// File: rtl/sercmd_memctl.sv
module sercmd_memctl
    import smc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_full,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [15:0]       sram_wdata,
    input  logic [15:0]       sram_rdata,
    output logic              pp_valid,
    output logic [15:0]       pp_data,
    output logic              proc_mode
);
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              split_empty;
    logic              ret_vld;
    logic              ret_proc;

    smc_byte_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .word_vld (word_vld),
        .word     (word)
    );

    smc_cmd_fsm #(.ADDR_W(ADDR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld    (word_vld),
        .word        (word),
        .split_empty (split_empty),
        .sram_en     (sram_en),
        .sram_we     (sram_we),
        .sram_addr   (sram_addr),
        .sram_wdata  (sram_wdata),
        .ret_vld     (ret_vld),
        .ret_proc    (ret_proc),
        .proc_mode   (proc_mode)
    );

    smc_rd_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .ret_vld     (ret_vld),
        .ret_proc    (ret_proc),
        .rdata       (sram_rdata),
        .tx_full     (tx_full),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .pp_valid    (pp_valid),
        .pp_data     (pp_data),
        .split_empty (split_empty)
    );

    // R9: nothing is strobed or offered in the first cycle after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sram_en && !pp_valid && !proc_mode));
endmodule

// File: tb/sercmd_memctl_bench.sv
module sercmd_memctl_bench;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          tx_full = 1'b0;
    logic          tx_valid;
    logic [7:0]    tx_byte;
    logic          sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [15:0]   sram_wdata;
    logic [15:0]   sram_rdata = '0;
    logic          pp_valid;
    logic [15:0]   pp_data;
    logic          proc_mode;

    int tests = 0;
    int fails = 0;

    logic [15:0] ram    [DEPTH];
    logic [15:0] shadow [DEPTH];
    logic [7:0]  exp_tx [$];
    logic [15:0] exp_pp [$];
    bit          bench_proc = 1'b0;
    bit          rand_full = 1'b0;
    bit          hold_full = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    int          en_cnt = 0;
    int          tx_cnt = 0;
    int          run = 0;
    int          max_run = 0;

    always #5 clk = ~clk;

    sercmd_memctl #(.ADDR_W(AW)) u_sercmd_memctl (
        .clk (clk), .rst_n (rst_n),
        .rx_valid (rx_valid), .rx_byte (rx_byte),
        .tx_full (tx_full), .tx_valid (tx_valid), .tx_byte (tx_byte),
        .sram_en (sram_en), .sram_we (sram_we), .sram_addr (sram_addr),
        .sram_wdata (sram_wdata), .sram_rdata (sram_rdata),
        .pp_valid (pp_valid), .pp_data (pp_data), .proc_mode (proc_mode)
    );

    // behavioural synchronous SRAM
    always @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) ram[sram_addr] <= sram_wdata;
            else         sram_rdata <= ram[sram_addr];
        end
    end

    // transmit-full driver
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_full = hold_full | (rand_full & lfsr[0]);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_en) en_cnt++;
            if (pp_valid) begin
                run++;
                if (run > max_run) max_run = run;
                if (exp_pp.size() == 0) check(0, "R6 unexpected stream word", pp_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_pp.pop_front();
                    check(pp_data == e, "R6 stream word", pp_data, e);
                end
            end else run = 0;
            if (tx_valid) begin
                tx_cnt++;
                if (tx_full) check(0, "R7 byte while full", tx_byte, 0);
                if (exp_tx.size() == 0) check(0, "R5 unexpected tx byte", tx_byte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(tx_byte == e, "R5 R1 tx byte", tx_byte, e);
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        send_byte(w[15:8]);
        send_byte(w[7:0]);
    endtask

    task automatic do_write(input int n, input int base, input logic [15:0] seed);
        send_word(16'h0000);
        send_word(16'(n));
        send_word(16'(base));
        for (int i = 0; i < n; i++) begin
            logic [15:0] v;
            v = seed + 16'(i * 16'h1111);
            shadow[(base + i) % DEPTH] = v;
            send_word(v);
        end
    endtask

    task automatic do_read(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            logic [15:0] v;
            v = shadow[(base + i) % DEPTH];
            if (bench_proc) exp_pp.push_back(v);
            else begin
                exp_tx.push_back(v[15:8]);
                exp_tx.push_back(v[7:0]);
            end
        end
        send_word(16'h0001);
        send_word(16'(n));
        send_word(16'(base));
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if (exp_pp.size() == 0 && exp_tx.size() == 0) break;
        end
        repeat (10) @(posedge clk);
        check(exp_pp.size() == 0 && exp_tx.size() == 0, "R3 burst completes",
              exp_pp.size() + exp_tx.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = '0;
            shadow[i] = '0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9 reset state, sampled while reset is still asserted
        check(!sram_en, "R9 sram_en in reset", sram_en, 0);
        check(!tx_valid && !pp_valid, "R9 valids in reset", {tx_valid, pp_valid}, 0);
        check(!proc_mode, "R9 mode in reset", proc_mode, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!sram_en && !pp_valid && !tx_valid, "R9 quiet after reset", sram_en, 0);

        // R1 R2 R5: write then read back to the serial link with random stalls
        do_write(4, 16'h10, 16'h12AB);
        repeat (4) @(posedge clk);
        check(ram[8'h10] == 16'h12AB, "R1 R2 high byte first in memory", ram[8'h10], 16'h12AB);
        check(ram[8'h13] == shadow[8'h13], "R2 last burst word", ram[8'h13], shadow[8'h13]);
        rand_full = 1'b1;
        do_read(4, 16'h10);
        drain();
        rand_full = 1'b0;

        // R7: held transmit-full blocks all bytes
        hold_full = 1'b1;
        @(posedge clk);
        tx_cnt = 0;
        do_read(2, 16'h11);
        repeat (40) @(posedge clk);
        check(tx_cnt == 0, "R7 no bytes while full", tx_cnt, 0);
        hold_full = 1'b0;
        drain();
        check(tx_cnt == 4, "R7 bytes after release", tx_cnt, 4);

        // R6: processing mode, continuous stream
        send_word(16'h0003);
        bench_proc = 1'b1;
        repeat (3) @(posedge clk);
        check(proc_mode, "R6 mode switch", proc_mode, 1);
        do_write(8, 16'h40, 16'h0003);
        tx_cnt = 0;
        max_run = 0;
        do_read(8, 16'h40);
        drain();
        check(max_run == 8, "R6 one word per clock", max_run, 8);
        check(tx_cnt == 0, "R6 no tx in processing mode", tx_cnt, 0);

        // R8: unknown codes ignored
        send_word(16'h0055);
        send_word(16'hFFFF);
        repeat (3) @(posedge clk);
        check(proc_mode, "R8 mode unchanged", proc_mode, 1);
        do_read(1, 16'h42);
        drain();

        // R4: zero length
        en_cnt = 0;
        send_word(16'h0001);
        send_word(16'h0000);
        send_word(16'h0020);
        repeat (20) @(posedge clk);
        check(en_cnt == 0, "R4 no access for zero count", en_cnt, 0);
        do_read(1, 16'h10);
        drain();
        check(en_cnt == 1, "R4 next word is a command", en_cnt, 1);

        // R2 R3: address wrap
        do_write(4, 16'hFE, 16'hBEE0);
        repeat (4) @(posedge clk);
        check(ram[8'hFF] == shadow[8'hFF], "R2 top word", ram[8'hFF], shadow[8'hFF]);
        check(ram[8'h00] == shadow[8'h00], "R2 wrapped word 0", ram[8'h00], shadow[8'h00]);
        check(ram[8'h01] == shadow[8'h01], "R2 wrapped word 1", ram[8'h01], shadow[8'h01]);
        do_read(4, 16'hFE);
        drain();

        // R5: back to memory mode
        send_word(16'h0002);
        bench_proc = 1'b0;
        repeat (3) @(posedge clk);
        check(!proc_mode, "R5 memory mode select", proc_mode, 0);
        do_read(2, 16'hFF);
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule